// File: doc/BRIEF.md
# Encoded Bus Status Cycle Monitor

This block observes a 3-bit encoded status bus from a processor. The status is registered on every clock. A dedicated all-ones code means the bus is idle. Every other code names the kind of transfer in progress. The block marks a new transfer when the status leaves the idle code, and it marks the close of the transfer when the status returns to idle. Each event appears as a single-clock pulse.

While a transfer is active, the status stays at one code for several clocks. It goes back to idle before the data phase ends. The block reports the code with the opening pulse. At the close, it adds one to a saturating counter kept for that code. A halt is reported like any other transfer, but it never counts, because no data moves. A jump from one active code straight to a different active code breaks the framing rules. The block flags it with an error pulse. The monitor then treats the later code as the kind of the open transfer.

Top module: `bstat_monitor`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, every counter slot is cleared and the monitor assumes the status was idle (3'b111). At the next sample, `start_o`, `end_o` and `err_o` are all low.
- R2: The status codes are: 3'b000 interrupt acknowledge, 3'b001 I/O read, 3'b010 I/O write, 3'b011 halt, 3'b100 code fetch, 3'b101 memory read, 3'b110 memory write, 3'b111 idle. In the clock after the edge that first registers a non-idle code following an idle sample, `start_o` is high and `start_kind_o` equals that code.
- R3: Holding the same non-idle code for further clocks produces no additional `start_o` pulse, so the pulse lasts exactly one clock.
- R4: In the clock after the edge that registers 3'b111 following a non-idle sample, `end_o` is high for one clock.
- R5: One clock after an `end_o` pulse, the counter slot of the code that was active is incremented by one. Slot c occupies `cnt_o[c*CNT_W +: CNT_W]` for c in 0..6, and no other slot changes.
- R6: A halt transfer (3'b011) gives a `start_o` pulse with kind 3'b011 and an `end_o` pulse, but it changes no counter. Slot 3 always reads zero.
- R7: When a registered non-idle code follows a different non-idle code, `err_o` pulses for one clock and `start_o` stays low. The transfer that later closes is counted under the later code.
- R8: A counter slot that holds 2**CNT_W-1 keeps that value on further closes of its code.
- R9: Asserting reset in the middle of a transfer drops it. No `end_o` follows, the counters read zero, and an active status still present after reset is reported as a fresh start.
- R10: Consecutive idle samples produce no `start_o`, `end_o` or `err_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | 3 | Encoded bus status, sampled every clock |
| start_o | output | 1 | One-clock pulse at the opening of a transfer |
| start_kind_o | output | 3 | Code of the opening transfer, valid with start_o |
| end_o | output | 1 | One-clock pulse at the close of a transfer |
| err_o | output | 1 | One-clock pulse on a direct active-to-active code change |
| cnt_o | output | 7*CNT_W | Per-code saturating counters, slot c at bits c*CNT_W |

## Verification
The bench instantiates the monitor with CNT_W set to 2, so every slot saturates at 3. A few memory-read transfers therefore reach the saturation point and go past it within a short run. The default width of 16 would need tens of thousands of transfers to reach the same corner. All seven active codes are run through complete transfers, so the bench can confirm that each slot changes on its own and that the halt slot never moves.

// File: rtl/bstat_pkg.sv
package bstat_pkg;
   localparam int unsigned CODE_W    = 3;
   localparam int unsigned NUM_CODES = 7;

   typedef enum logic [CODE_W-1:0] {
      ST_INTA  = 3'b000,
      ST_IORD  = 3'b001,
      ST_IOWR  = 3'b010,
      ST_HALT  = 3'b011,
      ST_FETCH = 3'b100,
      ST_MRD   = 3'b101,
      ST_MWR   = 3'b110,
      ST_IDLE  = 3'b111
   } bstat_e;
endpackage

// File: rtl/bstat_sampler.sv
// Two-deep status history: current registered sample and the one before it.
module bstat_sampler
   import bstat_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] status_i,
   output logic [CODE_W-1:0] samp_o,
   output logic [CODE_W-1:0] last_o
);
   logic [CODE_W-1:0] samp_q, last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         samp_q <= ST_IDLE;
         last_q <= ST_IDLE;
      end else begin
         samp_q <= status_i;
         last_q <= samp_q;
      end
   end

   assign samp_o = samp_q;
   assign last_o = last_q;
endmodule

// File: rtl/bstat_event_decode.sv
// Turns the status history into opening, closing and framing-error events.
module bstat_event_decode
   import bstat_pkg::*;
(
   input  logic [CODE_W-1:0] samp_i,
   input  logic [CODE_W-1:0] last_i,
   output logic              start_o,
   output logic              end_o,
   output logic              err_o
);
   logic samp_idle, last_idle;

   always_comb begin
      samp_idle = (samp_i == ST_IDLE);
      last_idle = (last_i == ST_IDLE);
      start_o   = last_idle && !samp_idle;
      end_o     = !last_idle && samp_idle;
      err_o     = !last_idle && !samp_idle && (samp_i != last_i);
   end
endmodule

// File: rtl/bstat_sat_counter.sv
// Saturating up-counter with synchronous clear.
module bstat_sat_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (inc_i && q != TOP)
         q <= q + 1'b1;
   end

   assign q_o = q;
endmodule

// File: rtl/bstat_monitor.sv
module bstat_monitor
   import bstat_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [2:0]                 status_i,
   output logic                       start_o,
   output logic [2:0]                 start_kind_o,
   output logic                       end_o,
   output logic                       err_o,
   output logic [7*CNT_W-1:0]         cnt_o
);
   localparam int unsigned SLOTS = NUM_CODES;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("bstat_monitor: CNT_W must lie in 1..32");
      end
   endgenerate

   logic [CODE_W-1:0] samp, last;
   logic              start_w, end_w, err_w;

   bstat_sampler i_sampler (
      .clk      (clk),
      .rst      (rst),
      .status_i (status_i),
      .samp_o   (samp),
      .last_o   (last)
   );

   bstat_event_decode i_decode (
      .samp_i  (samp),
      .last_i  (last),
      .start_o (start_w),
      .end_o   (end_w),
      .err_o   (err_w)
   );

   // On a close, the previous sample holds the code of the transfer that is ending.
   for (genvar c = 0; c < SLOTS; c++) begin : g_slot
      if (c == int'(ST_HALT)) begin : g_halt
         assign cnt_o[c*CNT_W +: CNT_W] = '0;
      end else begin : g_count
         logic hit;
         assign hit = end_w && (last == CODE_W'(c));
         bstat_sat_counter #(.W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc_i (hit),
            .q_o   (cnt_o[c*CNT_W +: CNT_W])
         );
      end
   end

   assign start_o      = start_w;
   assign start_kind_o = start_w ? samp : '0;
   assign end_o        = end_w;
   assign err_o        = err_w;
endmodule

// File: rtl/bstat_monitor_chk.sv
module bstat_monitor_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic               clk,
   input logic               rst,
   input logic [2:0]         status_i,
   input logic               start_o,
   input logic [2:0]         start_kind_o,
   input logic               end_o,
   input logic               err_o,
   input logic [7*CNT_W-1:0] cnt_o
);
   // R2: the reported kind is the code presented one clock earlier
   a_r2_kind_matches: assert property (@(posedge clk) disable iff (rst)
      start_o |-> (start_kind_o == $past(status_i)) && (start_kind_o != 3'b111));

   // R3: an opening pulse never lasts two clocks
   a_r3_single_start: assert property (@(posedge clk) disable iff (rst)
      start_o |=> !start_o);

   // R4: a close is seen only after idle was presented
   a_r4_end_after_idle: assert property (@(posedge clk) disable iff (rst)
      end_o |-> $past(status_i) == 3'b111);

   // R7: a framing error never coincides with an opening or a close
   a_r7_err_alone: assert property (@(posedge clk) disable iff (rst)
      err_o |-> !start_o && !end_o);

   // R10: opening and close are exclusive
   a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(start_o && end_o));

   for (genvar c = 0; c < 7; c++) begin : g_chk
      // R5, R8: a slot holds or steps by one, and only after a close
      a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> (cnt_o[c*CNT_W +: CNT_W] == $past(cnt_o[c*CNT_W +: CNT_W])) ||
                         ((cnt_o[c*CNT_W +: CNT_W] == $past(cnt_o[c*CNT_W +: CNT_W]) + 1'b1) &&
                          $past(end_o)));
   end
endmodule

bind bstat_monitor bstat_monitor_chk #(.CNT_W(CNT_W)) i_chk (
   .clk          (clk),
   .rst          (rst),
   .status_i     (status_i),
   .start_o      (start_o),
   .start_kind_o (start_kind_o),
   .end_o        (end_o),
   .err_o        (err_o),
   .cnt_o        (cnt_o)
);

// File: tb/test_bstat_monitor.sv
module test_bstat_monitor;
   localparam int CW  = 2;
   localparam int TOP = (1 << CW) - 1;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [2:0]      status_i = 3'b111;
   logic            start_o, end_o, err_o;
   logic [2:0]      start_kind_o;
   logic [7*CW-1:0] cnt_o;

   int errors = 0;
   int checks = 0;
   int model [7];

   always #2.5 clk = ~clk;

   bstat_monitor #(.CNT_W(CW)) i_bstat_monitor (
      .clk          (clk),
      .rst          (rst),
      .status_i     (status_i),
      .start_o      (start_o),
      .start_kind_o (start_kind_o),
      .end_o        (end_o),
      .err_o        (err_o),
      .cnt_o        (cnt_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // present one status sample; afterwards outputs reflect that sample
   task automatic cyc(input logic [2:0] code);
      status_i = code;
      @(negedge clk);
   endtask

   task automatic chk_cnts(input string req);
      for (int c = 0; c < 7; c++)
         chk(req, int'(cnt_o[c*CW +: CW]), model[c]);
   endtask

   task automatic bump(input int code);
      if (code != 3 && model[code] < TOP) model[code]++;
   endtask

   task automatic run_xfer(input logic [2:0] code, input int hold);
      cyc(code);
      chk("R2 start", int'(start_o), 1);
      chk("R2 kind", int'(start_kind_o), int'(code));
      for (int i = 1; i < hold; i++) begin
         cyc(code);
         chk("R3 no restart", int'(start_o), 0);
      end
      cyc(3'b111);
      chk("R4 end", int'(end_o), 1);
      bump(int'(code));
      cyc(3'b111);
      chk("R4 end one clock", int'(end_o), 0);
      chk_cnts(code == 3'b011 ? "R6 halt no count" : "R5 count");
   endtask

   task automatic t_reset;
      for (int c = 0; c < 7; c++) model[c] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 start", int'(start_o), 0);
      chk("R1 end", int'(end_o), 0);
      chk("R1 err", int'(err_o), 0);
      chk_cnts("R1 counters");
   endtask

   task automatic t_all_codes;
      for (int c = 0; c < 7; c++) run_xfer(3'(c), 2);
   endtask

   task automatic t_long_hold;
      run_xfer(3'b100, 5);
   endtask

   task automatic t_idle;
      for (int i = 0; i < 3; i++) begin
         cyc(3'b111);
         chk("R10 idle", int'({start_o, end_o, err_o}), 0);
      end
   endtask

   task automatic t_switch;
      cyc(3'b101);
      chk("R7 start", int'(start_o), 1);
      cyc(3'b110);
      chk("R7 err", int'(err_o), 1);
      chk("R7 no start", int'(start_o), 0);
      cyc(3'b110);
      chk("R7 err one clock", int'(err_o), 0);
      cyc(3'b111);
      chk("R7 end", int'(end_o), 1);
      bump(6);
      cyc(3'b111);
      chk_cnts("R7 later code counted");
   endtask

   task automatic t_saturate;
      for (int i = 0; i < 5; i++) run_xfer(3'b101, 1);
      chk("R8 saturated", int'(cnt_o[5*CW +: CW]), TOP);
   endtask

   task automatic t_mid_reset;
      cyc(3'b001);
      chk("R9 start", int'(start_o), 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int c = 0; c < 7; c++) model[c] = 0;
      chk_cnts("R9 cleared");
      chk("R9 no start in reset", int'(start_o), 0);
      cyc(3'b001);
      chk("R9 fresh start", int'(start_o), 1);
      chk("R9 fresh kind", int'(start_kind_o), 1);
      chk("R9 no end", int'(end_o), 0);
      cyc(3'b111);
      chk("R9 end", int'(end_o), 1);
      bump(1);
      cyc(3'b111);
      chk_cnts("R9 count after reset");
   endtask

   initial begin
      t_reset();
      t_idle();
      t_all_codes();
      t_long_hold();
      t_switch();
      t_saturate();
      t_mid_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule